// File: doc/BRIEF.md
# Boost Frequency Target Calculator

This block runs the arithmetic of an activity-driven memory clock governor. Each time the activity monitor finishes a sampling window, software or a sequencer presents the window's average activity count, the two consecutive-breach flags, the clock limits, the per-client tuning values and the current CPU clock, then pulses `start`. The block first updates a persistent boost term. A sustained high-activity breach grows it by a percentage plus a fixed step. A sustained low-activity breach shrinks it by a percentage. The block then derives a target memory clock in kHz. That target can be raised to a floor picked from a CPU-clock lookup.

All multiplies and divides go through a bit-serial shift-add multiplier and a restoring divider that share one set of registers, so the block costs a few adders and comparators. The price is latency: a run with an event takes 288 cycles and a run without one takes 208. The boost, the target and the two detector-enable outputs change together, in the cycle `done` pulses. Inputs must be held steady from `start` until one cycle after `done`.

Top module: `boost_target_calc`

## Requirements
- R1: When `evt_upper` is set, the new boost is floor(boost * up_coeff / 100) + 16000. If that is at or above `max_khz`, the boost becomes `max_khz` and `above_en` keeps the value of `above_en_in`. Otherwise `above_en` is driven to 1.
- R2: When only `evt_lower` is set, the new boost is floor(boost * down_coeff / 100), and a result below 8000 becomes 0. The value 8000 itself is kept. `below_en` is driven to 1 only when the new boost is nonzero; otherwise it takes `below_en_in`, subject to R8.
- R3: An upper event drives `below_en` to 1 and a lower event drives `above_en` to 1, whatever the enable inputs are.
- R4: When both event flags are set, only the upper-event rule of R1 is applied.
- R5: With neither flag set, the boost keeps its value and the enables follow `above_en_in`/`below_en_in`, subject to R8.
- R6: The target is floor(floor(floor(avg_count / 12) * floor(10000 / up_thresh)) / 100) plus the new boost. `up_thresh` must be nonzero.
- R7: When `dep_thresh` is nonzero and `avg_count` >= `dep_thresh`, the target is raised to at least a floor chosen from `cpu_khz`. The thresholds are checked from the highest down: cpu >= 1400000 gives `max_khz`, >= 1200000 gives 750000, >= 1100000 gives 600000, >= 1000000 gives 500000, >= 800000 gives 375000, >= 500000 gives 200000, >= 250000 gives 100000, and anything lower gives 0. A floor at or above `max_khz` is replaced by `max_khz`.
- R8: When `dep_thresh` is nonzero, `avg_count` >= `dep_thresh` forces `below_en` to 1. If the average is below the threshold and the new boost is 0, `below_en` is forced to 0.
- R9: `done` is a one-cycle pulse. It comes 288 clock edges after the accepting edge of `start` when either event flag is set, and 208 edges after it otherwise. `busy` is high in between. The four result outputs change only in the `done` cycle.
- R10: A `start` pulse while `busy` is high is ignored: no extra run and no change in timing or results.
- R11: After reset, `boost_khz`, `target_khz`, `above_en`, `below_en`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one update; accepted only when not busy |
| evt_upper | input | 1 | Consecutive above-watermark breach seen |
| evt_lower | input | 1 | Consecutive below-watermark breach seen |
| avg_count | input | 32 | Average activity count of the window |
| max_khz | input | 32 | Highest allowed memory clock, kHz |
| up_coeff | input | 16 | Boost growth factor, percent |
| down_coeff | input | 16 | Boost decay factor, percent (at most 100) |
| up_thresh | input | 8 | Upper watermark percentage, nonzero |
| dep_thresh | input | 32 | Activity level enabling the CPU floor; 0 disables |
| cpu_khz | input | 32 | Current CPU clock, kHz |
| above_en_in | input | 1 | Present above-detector enable |
| below_en_in | input | 1 | Present below-detector enable |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| boost_khz | output | 32 | Boost term, kHz |
| target_khz | output | 36 | Target memory clock, kHz |
| above_en | output | 1 | Updated above-detector enable |
| below_en | output | 1 | Updated below-detector enable |

## Verification
The bench chains runs so that the boost climbs, saturates against a lowered limit, and decays through the exact 8000 boundary down to zero. A wrong comparison at 8000 shows up as a zero boost one run early. A missing clamp shows up as a boost above the limit. Other runs set both flags, press `start` mid-run and move the CPU clock across table rows, including a row whose floor is above the limit. A wrong priority would shrink the boost instead of growing it. A design that honours a late `start` would give a second `done` or a shifted one. A wrong floor rule would leave the target at its activity value or beyond the limit.

// File: rtl/boost_target_calc.sv
module boost_target_calc #(
  parameter int FW     = 32,
  parameter int CW     = 16,
  parameter int TW_W   = 8,
  parameter int STEP   = 16000,
  parameter int PERIOD = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            evt_upper,
  input  logic            evt_lower,
  input  logic [FW-1:0]   avg_count,
  input  logic [FW-1:0]   max_khz,
  input  logic [CW-1:0]   up_coeff,
  input  logic [CW-1:0]   down_coeff,
  input  logic [TW_W-1:0] up_thresh,
  input  logic [FW-1:0]   dep_thresh,
  input  logic [FW-1:0]   cpu_khz,
  input  logic            above_en_in,
  input  logic            below_en_in,
  output logic            busy,
  output logic            done,
  output logic [FW-1:0]   boost_khz,
  output logic [FW+3:0]   target_khz,
  output logic            above_en,
  output logic            below_en
);
  localparam int PW      = 2 * FW;
  localparam int TW      = FW + 4;
  localparam int CNTW    = $clog2(PW);
  localparam int MAX_LAT = 2 * CW + 4 * PW;
  localparam int LATW    = $clog2(MAX_LAT) + 2;

  typedef enum logic [2:0] {S_IDLE, S_BMUL, S_BDIV, S_ADIV, S_CDIV, S_TMUL, S_TDIV} st_t;
  st_t state;

  logic [PW-1:0]   acc, mcand, quo, dvsr;
  logic [CW-1:0]   mplier;
  logic [CNTW-1:0] cnt;
  logic [FW-1:0]   nb;
  logic            sat;

  function automatic logic [FW-1:0] cpu_floor(input logic [FW-1:0] cpu, input logic [FW-1:0] mx);
    logic [FW-1:0] v;
    if      (cpu >= FW'(1400000)) v = mx;
    else if (cpu >= FW'(1200000)) v = FW'(750000);
    else if (cpu >= FW'(1100000)) v = FW'(600000);
    else if (cpu >= FW'(1000000)) v = FW'(500000);
    else if (cpu >= FW'(800000))  v = FW'(375000);
    else if (cpu >= FW'(500000))  v = FW'(200000);
    else if (cpu >= FW'(250000))  v = FW'(100000);
    else                          v = '0;
    return (v >= mx) ? mx : v;
  endfunction

  logic [PW-1:0] mul_acc, trial, rem_nx, quo_nx, up_sum;
  logic          ge, last_mul, last_div, up_sat, dep_on, dep_hit;
  logic [FW-1:0] up_nb, lo_nb, floor_v;
  logic [TW-1:0] t_sum, t_fin;
  logic          ab_nx, be_nx;

  assign busy     = (state != S_IDLE);
  assign mul_acc  = mplier[0] ? acc + mcand : acc;
  assign trial    = {acc[PW-2:0], quo[PW-1]};
  assign ge       = (trial >= dvsr);
  assign rem_nx   = ge ? trial - dvsr : trial;
  assign quo_nx   = {quo[PW-2:0], ge};
  assign last_mul = (cnt == CNTW'(CW - 1));
  assign last_div = (cnt == CNTW'(PW - 1));

  assign up_sum  = quo_nx + PW'(STEP);
  assign up_sat  = (up_sum >= PW'(max_khz));
  assign up_nb   = up_sat ? max_khz : up_sum[FW-1:0];
  assign lo_nb   = (quo_nx < PW'(STEP / 2)) ? '0 : quo_nx[FW-1:0];

  assign dep_on  = (dep_thresh != '0);
  assign dep_hit = dep_on && (avg_count >= dep_thresh);
  assign floor_v = cpu_floor(cpu_khz, max_khz);
  assign t_sum   = quo_nx[TW-1:0] + TW'(nb);
  assign t_fin   = (dep_hit && (TW'(floor_v) > t_sum)) ? TW'(floor_v) : t_sum;

  always_comb begin
    ab_nx = above_en_in;
    be_nx = below_en_in;
    if (evt_upper) begin
      be_nx = 1'b1;
      if (!sat) ab_nx = 1'b1;
    end else if (evt_lower) begin
      ab_nx = 1'b1;
      if (nb != '0) be_nx = 1'b1;
    end
    if (dep_on) begin
      if (avg_count >= dep_thresh) be_nx = 1'b1;
      else if (nb == '0)           be_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; acc <= '0; mcand <= '0; quo <= '0; dvsr <= '0;
      mplier <= '0; cnt <= '0; nb <= '0; sat <= 1'b0; done <= 1'b0;
      boost_khz <= '0; target_khz <= '0; above_en <= 1'b0; below_en <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cnt <= '0;
          acc <= '0;
          if (evt_upper || evt_lower) begin
            mcand  <= PW'(boost_khz);
            mplier <= evt_upper ? up_coeff : down_coeff;
            state  <= S_BMUL;
          end else begin
            nb    <= boost_khz;
            sat   <= 1'b0;
            quo   <= PW'(avg_count);
            dvsr  <= PW'(PERIOD);
            state <= S_ADIV;
          end
        end
        S_BMUL, S_TMUL: begin
          acc    <= mul_acc;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          cnt    <= cnt + 1'b1;
          if (last_mul) begin
            quo   <= mul_acc;
            acc   <= '0;
            dvsr  <= PW'(100);
            cnt   <= '0;
            state <= (state == S_BMUL) ? S_BDIV : S_TDIV;
          end
        end
        S_BDIV, S_ADIV, S_CDIV, S_TDIV: begin
          acc <= rem_nx;
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (last_div) begin
            acc <= '0;
            cnt <= '0;
            case (state)
              S_BDIV: begin
                nb    <= evt_upper ? up_nb : lo_nb;
                sat   <= evt_upper && up_sat;
                quo   <= PW'(avg_count);
                dvsr  <= PW'(PERIOD);
                state <= S_ADIV;
              end
              S_ADIV: begin
                mcand <= quo_nx;
                quo   <= PW'(10000);
                dvsr  <= PW'(up_thresh);
                state <= S_CDIV;
              end
              S_CDIV: begin
                mplier <= quo_nx[CW-1:0];
                state  <= S_TMUL;
              end
              default: begin
                boost_khz  <= nb;
                target_khz <= t_fin;
                above_en   <= ab_nx;
                below_en   <= be_nx;
                done       <= 1'b1;
                state      <= S_IDLE;
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [LATW-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 1'b1;
    else           lat_cnt <= '0;
  end

  AST_UP_CLAMP:    assert property (@(posedge clk) disable iff (!rst_n) done && evt_upper |-> boost_khz <= max_khz); // R1
  AST_LO_DECAY:    assert property (@(posedge clk) disable iff (!rst_n) done && !evt_upper && evt_lower |-> (boost_khz == '0 || boost_khz >= FW'(STEP / 2))); // R2
  AST_OPP_UP:      assert property (@(posedge clk) disable iff (!rst_n) done && evt_upper && boost_khz != '0 |-> below_en); // R3
  AST_OPP_LO:      assert property (@(posedge clk) disable iff (!rst_n) done && !evt_upper && evt_lower |-> above_en); // R3
  AST_DEP_FORCE:   assert property (@(posedge clk) disable iff (!rst_n) done && dep_on && avg_count >= dep_thresh |-> below_en); // R8
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_OUT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(boost_khz) && $stable(target_khz) && $stable(above_en) && $stable(below_en)); // R9
  AST_LAT_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) lat_cnt <= LATW'(MAX_LAT)); // R9
endmodule

// File: tb/tb_boost_target_calc.sv
`timescale 1ns/1ps
module tb_boost_target_calc;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic evt_upper = 0, evt_lower = 0, ai = 0, bi = 0;
  logic [31:0] avg = 0, mx = 0, dep = 0, cpu = 0;
  logic [15:0] upc = 0, dnc = 0;
  logic [7:0]  thr = 1;
  logic busy, done, above_en, below_en;
  logic [31:0] boost_khz;
  logic [35:0] target_khz;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  boost_target_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .evt_upper(evt_upper), .evt_lower(evt_lower),
    .avg_count(avg), .max_khz(mx), .up_coeff(upc), .down_coeff(dnc), .up_thresh(thr),
    .dep_thresh(dep), .cpu_khz(cpu), .above_en_in(ai), .below_en_in(bi),
    .busy(busy), .done(done), .boost_khz(boost_khz), .target_khz(target_khz),
    .above_en(above_en), .below_en(below_en));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint floor_of(input longint c, input longint m);
    longint v;
    if      (c >= 1400000) v = m;
    else if (c >= 1200000) v = 750000;
    else if (c >= 1100000) v = 600000;
    else if (c >= 1000000) v = 500000;
    else if (c >= 800000)  v = 375000;
    else if (c >= 500000)  v = 200000;
    else if (c >= 250000)  v = 100000;
    else                   v = 0;
    return (v >= m) ? m : v;
  endfunction

  // behavioural reference, advanced on every rising edge
  longint m_boost, m_target, p_boost, p_target;
  bit m_ab, m_be, p_ab, p_be, m_busy, m_done;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_boost = 0; m_target = 0; m_ab = 0; m_be = 0; m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_boost = p_boost; m_target = p_target; m_ab = p_ab; m_be = p_be;
          m_done = 1; m_busy = 0;
        end
      end else if (start) begin
        longint b, t;
        bit s;
        b = m_boost; s = 0; p_ab = ai; p_be = bi;
        if (evt_upper) begin
          b = b * upc / 100 + 16000;
          if (b >= mx) begin b = mx; s = 1; end
          p_be = 1;
          if (!s) p_ab = 1;
        end else if (evt_lower) begin
          b = b * dnc / 100;
          p_ab = 1;
          if (b < 8000) b = 0; else p_be = 1;
        end
        t = (longint'(avg) / 12) * (10000 / longint'(thr)) / 100 + b;
        if (dep != 0) begin
          if (avg >= dep) begin
            p_be = 1;
            if (floor_of(cpu, mx) > t) t = floor_of(cpu, mx);
          end else if (b == 0) p_be = 0;
        end
        p_boost = b; p_target = t;
        m_cnt = (evt_upper || evt_lower) ? 288 : 208;
        m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R9 model busy", busy, m_busy);
      check("R9 model done", done, m_done);
      check("R1 R2 model boost", boost_khz, m_boost);
      check("R6 R7 model target", target_khz, m_target);
      check("R3 R8 model above_en", above_en, m_ab);
      check("R3 R8 model below_en", below_en, m_be);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int lat;
  task automatic run(input bit up, lo, input int poke);
    evt_upper = up; evt_lower = lo; start = 1;
    @(negedge clk); start = 0; lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk); lat++;
      start = (poke != 0 && lat == poke);
    end
    start = 0;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input longint b, t, input bit a, e);
    check({tag, " boost"}, boost_khz, b);
    check({tag, " target"}, target_khz, t);
    check({tag, " above_en"}, above_en, a);
    check({tag, " below_en"}, below_en, e);
  endtask

  initial begin
    mx = 2000000; avg = 120000; thr = 60; upc = 200; dnc = 50;
    repeat (3) @(negedge clk);
    expect_out("R11 reset", 0, 0, 0, 0);
    check("R11 reset busy", busy, 0);
    check("R11 reset done", done, 0);
    rst_n = 1;
    @(negedge clk);

    run(1, 0, 0); expect_out("R1 first step", 16000, 32600, 1, 1);
    check("R9 event latency", lat, 288);
    run(1, 0, 0); expect_out("R1 growth", 48000, 64600, 1, 1);
    mx = 50000;
    run(1, 0, 0); expect_out("R1 saturate", 50000, 66600, 0, 1);
    mx = 2000000;
    run(0, 1, 0); expect_out("R2 R3 decay", 25000, 41600, 1, 1);
    run(0, 1, 0); expect_out("R2 decay again", 12500, 29100, 1, 1);
    run(0, 1, 0); expect_out("R2 drop to zero", 0, 16600, 1, 0);
    run(1, 1, 0); expect_out("R4 both flags", 16000, 32600, 1, 1);
    ai = 1;
    run(0, 0, 0); expect_out("R5 no event", 16000, 32600, 1, 0);
    check("R9 plain latency", lat, 208);
    ai = 0; dep = 50000; cpu = 1150000;
    run(0, 0, 0); expect_out("R7 R8 cpu floor", 16000, 600000, 0, 1);
    cpu = 1300000; mx = 700000;
    run(0, 0, 0); expect_out("R7 floor clamp", 16000, 700000, 0, 1);
    mx = 2000000; dep = 200000; cpu = 1500000;
    run(0, 1, 0); expect_out("R2 R7 boundary 8000", 8000, 24600, 1, 1);
    bi = 1;
    run(0, 1, 0); expect_out("R8 below cleared", 0, 16600, 1, 0);
    bi = 0; dep = 0; avg = 240000; thr = 27;
    run(0, 0, 0); expect_out("R6 other threshold", 0, 74000, 0, 0);
    run(1, 0, 10); expect_out("R10 mid-run start", 16000, 90000, 1, 1);
    check("R10 latency kept", lat, 288);
    begin
      int extra = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R10 no second run", extra, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule